// File: doc/BRIEF.md
# Dual-Pointer Instruction Fetch Sequencer

This block steers instruction fetch in a small 16-bit microcoded machine. It keeps two address pointers: a user program counter for program RAM and a firmware pointer for firmware ROM. Both memories cover the same address range, and a segment select picks which one a fetch reads. Each user word is classified by its top bit. If that bit is clear, the word is a microcode instruction and passes to the instruction register. If it is set, the word calls a firmware routine whose start address is held in the low 15 bits.

While a call is active, words come from ROM through the firmware pointer. A dedicated return word switches fetch back to the user counter, which has been left pointing at the word after the call. There is no call stack. A call seen while already in firmware is refused: it raises a one-cycle error pulse and is skipped. The firmware pointer counts across the full ROM range, so code in the upper half is reachable only by running into it from below.

Memory is driven through a single-outstanding request/response pair. The sequencer raises a request with an address and a segment, then waits for a valid response before it consumes the word and issues the next request.

Top module: `dual_ptr_fetch`

## Requirements
- R1: After synchronous reset the block is in user mode with the program counter at 0: it requests address 0 from RAM (`req_seg`=0) and shows no `ir_valid`, `ret_strobe` or `call_err`.
- R2: In user mode a fetched word with bit 15 = 0 appears on `ir_word` with `ir_valid` high one cycle after the response, and the program counter advances by one.
- R3: In user mode a word with bit 15 = 1 produces no instruction output; the next fetch reads ROM at the zero-extended address in bits 14:0, and the program counter advances past the call word.
- R4: In firmware mode a word with bit 15 = 0 is output like R2 and the firmware pointer advances by one, wrapping over 16 bits, so address 0x8000 and above are reached by running from 0x7FFF.
- R5: In firmware mode the return word 16'hFFFF pulses `ret_strobe`, produces no instruction output, and the next fetch reads RAM at the saved program counter.
- R6: In firmware mode a word with bit 15 = 1 other than the return word pulses `call_err`, produces no instruction output, leaves firmware mode and the firmware pointer's target unchanged, and the fetch continues at the next ROM word.
- R7: `req_seg` is 0 for every RAM fetch and 1 for every ROM fetch.
- R8: At most one request is outstanding: `req_valid` is low from the cycle after a request until a response arrives, and no pointer moves or output is produced while waiting.
- R9: `ir_valid`, `ret_strobe` and `call_err` are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | output | 1 | Fetch request, high when no fetch is outstanding |
| req_addr | output | 16 | Fetch address from the active pointer |
| req_seg | output | 1 | Segment select: 0 RAM, 1 ROM |
| rsp_valid | input | 1 | Fetched word is valid this cycle |
| rsp_data | input | 16 | Fetched word |
| ir_valid | output | 1 | Instruction register load strobe |
| ir_word | output | 16 | Instruction word to the instruction register |
| ret_strobe | output | 1 | Return from firmware decoded |
| call_err | output | 1 | Call attempted inside firmware, refused |

## Verification
The hardest situation to reach is the firmware pointer crossing from the callable lower half into the upper half of ROM. That code can be entered only by running past 0x7FFF, never by a call. The stimulus uses the all-ones user word, which is a call to 0x7FFF, and places a microcode word there, so the next fetch lands at 0x8000. A refused nested call is also placed in the middle of a routine, and memory is held stalled right after reset, to show that the saved user counter and the wait behaviour survive both.

// File: rtl/fseq_pkg.sv
// Shared types for the dual-pointer fetch sequencer.
// Assumes: one classification per fetched word, two fetch modes.
package fseq_pkg;
    typedef enum logic [1:0] {
        WK_MICRO   = 2'd0,
        WK_CALL    = 2'd1,
        WK_RET     = 2'd2,
        WK_BADCALL = 2'd3
    } word_kind_e;

    typedef enum logic {
        M_USER = 1'b0,
        M_FW   = 1'b1
    } fetch_mode_e;
endpackage

// File: rtl/fseq_decode.sv
// Classifies a fetched word according to the current fetch mode.
// Assumes: bit DATA_W-1 is the mode flag; RET_WORD has that flag set.
module fseq_decode
    import fseq_pkg::*;
#(
    parameter int unsigned          DATA_W   = 16,
    parameter logic [DATA_W-1:0]    RET_WORD = '1
) (
    input  fetch_mode_e         mode,
    input  logic [DATA_W-1:0]   word,
    output word_kind_e          kind
);
    localparam int unsigned FLAG_BIT = DATA_W - 1;

    // Purpose: map mode and flag bit to a word kind.
    always_comb begin
        if (mode == M_USER) begin
            kind = word[FLAG_BIT] ? WK_CALL : WK_MICRO;
        end else if (word == RET_WORD) begin
            kind = WK_RET;
        end else begin
            kind = word[FLAG_BIT] ? WK_BADCALL : WK_MICRO;
        end
    end
endmodule

// File: rtl/fseq_ptrs.sv
// Holds the user program counter and the firmware pointer, and drives
// the fetch address and segment from the one selected by the mode.
// Assumes: at most one of adv_fw and load_fw is high in a cycle.
module fseq_ptrs
    import fseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  fetch_mode_e         mode,
    input  logic                adv_pc,
    input  logic                adv_fw,
    input  logic                load_fw,
    input  logic [ADDR_W-1:0]   load_val,
    output logic [ADDR_W-1:0]   addr,
    output logic                seg
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] fw_q;

    // Purpose: user program counter, steps past each accepted user word.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= '0;
        else if (adv_pc) pc_q <= pc_q + ONE;
    end

    // Purpose: firmware pointer, loaded on a call, stepped in firmware.
    always_ff @(posedge clk) begin
        if (!rst_n)       fw_q <= '0;
        else if (load_fw) fw_q <= load_val;
        else if (adv_fw)  fw_q <= fw_q + ONE;
    end

    // Purpose: select the active pointer and segment for the fetch port.
    always_comb begin
        addr = (mode == M_FW) ? fw_q : pc_q;
        seg  = (mode == M_FW);
    end
endmodule

// File: rtl/dual_ptr_fetch.sv
// Fetch sequencer with a user counter and a dedicated firmware pointer.
// Issues one memory request at a time, classifies each returned word and
// either loads the instruction register, enters firmware, returns from it
// or flags a refused nested call.
// Assumes: memory answers each request exactly once, never unasked.
module dual_ptr_fetch
    import fseq_pkg::*;
#(
    parameter int unsigned          DATA_W   = 16,
    parameter int unsigned          ADDR_W   = 16,
    parameter logic [DATA_W-1:0]    RET_WORD = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic                req_valid,
    output logic [ADDR_W-1:0]   req_addr,
    output logic                req_seg,
    input  logic                rsp_valid,
    input  logic [DATA_W-1:0]   rsp_data,
    output logic                ir_valid,
    output logic [DATA_W-1:0]   ir_word,
    output logic                ret_strobe,
    output logic                call_err
);
    localparam int unsigned TGT_W = DATA_W - 1;

    logic        pend_q;
    fetch_mode_e mode_q;
    word_kind_e  kind;
    logic        accept;
    logic        is_user;

    assign accept    = pend_q & rsp_valid;
    assign is_user   = (mode_q == M_USER);
    assign req_valid = ~pend_q;

    fseq_decode #(
        .DATA_W   (DATA_W),
        .RET_WORD (RET_WORD)
    ) u_dec (
        .mode (mode_q),
        .word (rsp_data),
        .kind (kind)
    );

    fseq_ptrs #(
        .ADDR_W (ADDR_W)
    ) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .adv_pc   (accept & is_user),
        .adv_fw   (accept & ~is_user & (kind == WK_MICRO || kind == WK_BADCALL)),
        .load_fw  (accept & (kind == WK_CALL)),
        .load_val (ADDR_W'(rsp_data[TGT_W-1:0])),
        .addr     (req_addr),
        .seg      (req_seg)
    );

    // Purpose: track the single outstanding request.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (accept)    pend_q <= 1'b0;
        else if (req_valid) pend_q <= 1'b1;
    end

    // Purpose: switch fetch mode on calls and returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_USER;
        end else if (accept) begin
            if (kind == WK_CALL)     mode_q <= M_FW;
            else if (kind == WK_RET) mode_q <= M_USER;
        end
    end

    // Purpose: register the instruction output and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_valid   <= 1'b0;
            ir_word    <= '0;
            ret_strobe <= 1'b0;
            call_err   <= 1'b0;
        end else begin
            ir_valid   <= accept & (kind == WK_MICRO);
            ret_strobe <= accept & (kind == WK_RET);
            call_err   <= accept & (kind == WK_BADCALL);
            if (accept && kind == WK_MICRO) ir_word <= rsp_data;
        end
    end
endmodule

// File: rtl/fseq_checker.sv
// Temporal checks on the fetch sequencer ports, bound to the top module.
// Assumes: memory never answers without a request outstanding.
module fseq_checker #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_seg,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_data,
    input logic              ir_valid,
    input logic [DATA_W-1:0] ir_word,
    input logic              ret_strobe,
    input logic              call_err
);
    p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !rsp_valid) |=> ($stable(req_addr) && !ir_valid));

    p_pulses_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ir_valid, ret_strobe, call_err}));

    p_ir_flag_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ir_valid |-> !ir_word[DATA_W-1]);

    p_ret_to_ram_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_strobe |-> (req_valid && !req_seg));

    p_err_stays_rom_r6: assert property (@(posedge clk) disable iff (!rst_n)
        call_err |-> (req_valid && req_seg));

    p_call_targets_rom_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !req_valid && !req_seg && rsp_data[DATA_W-1])
        |=> (req_seg && req_addr == ADDR_W'($past(rsp_data[DATA_W-2:0]))));
endmodule

bind dual_ptr_fetch fseq_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_seg    (req_seg),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .ir_valid   (ir_valid),
    .ir_word    (ir_word),
    .ret_strobe (ret_strobe),
    .call_err   (call_err)
);

// File: tb/tb_dual_ptr_fetch.sv
module tb_dual_ptr_fetch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid;
    logic [15:0] req_addr;
    logic        req_seg;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic        ir_valid;
    logic [15:0] ir_word;
    logic        ret_strobe;
    logic        call_err;
    logic        hold = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dual_ptr_fetch dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_seg(req_seg),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .ir_valid(ir_valid), .ir_word(ir_word),
        .ret_strobe(ret_strobe), .call_err(call_err)
    );

    // Program contents: RAM when seg=0, ROM when seg=1.
    function automatic logic [15:0] mem_word(input logic seg, input logic [15:0] a);
        if (!seg) begin
            case (a)
                16'h0000: return 16'h0123;
                16'h0001: return 16'h8010;   // call 0x0010
                16'h0002: return 16'h0456;
                16'h0003: return 16'hFFFF;   // call 0x7FFF
                16'h0004: return 16'h0777;
                default:  return 16'h0E0E;
            endcase
        end else begin
            case (a)
                16'h0010: return 16'h1111;
                16'h0011: return 16'h8005;   // nested call, refused
                16'h0012: return 16'h2222;
                16'h7FFF: return 16'h0AAA;
                16'h8000: return 16'h0BBB;   // upper half
                default:  return 16'hFFFF;   // return word
            endcase
        end
    endfunction

    // Memory model: answers each request two edges later unless held.
    logic        mq_pend;
    logic [15:0] mq_addr;
    logic        mq_seg;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mq_pend   <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            mq_addr   <= '0;
            mq_seg    <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (mq_pend && !hold) begin
                rsp_valid <= 1'b1;
                rsp_data  <= mem_word(mq_seg, mq_addr);
                mq_pend   <= 1'b0;
            end
            if (req_valid) begin
                mq_pend <= 1'b1;
                mq_addr <= req_addr;
                mq_seg  <= req_seg;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected event stream {ir_valid, ret_strobe, call_err, ir_word}.
    localparam int N_EVT = 10;
    localparam logic [18:0] EVT [N_EVT] = '{
        {3'b100, 16'h0123},   // R2 user microcode
        {3'b100, 16'h1111},   // R3 first routine word
        {3'b001, 16'h0000},   // R6 refused nested call
        {3'b100, 16'h2222},   // R6 routine continues
        {3'b010, 16'h0000},   // R5 return
        {3'b100, 16'h0456},   // R5 resume after call
        {3'b100, 16'h0AAA},   // R3 call to 0x7FFF
        {3'b100, 16'h0BBB},   // R4 upper half by increment
        {3'b010, 16'h0000},   // R5 return
        {3'b100, 16'h0777}    // R2 user continues
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 9:    return "R2";
            1, 6:    return "R3";
            7:       return "R4";
            4, 5, 8: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Wait at negedges until any event pulse is seen.
    task automatic wait_event(output logic [18:0] got);
        got = '0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (ir_valid || ret_strobe || call_err) begin
                got = {ir_valid, ret_strobe, call_err, ir_valid ? ir_word : 16'h0000};
                return;
            end
        end
        check("R8 watchdog", 32'd0, 32'd1);
    endtask

    initial begin
        logic [18:0] got;
        fork
            begin
                repeat (3) @(negedge clk);
                // R1 reset state
                @(negedge clk);
                rst_n = 1'b1;
                check("R1 req_valid", 32'(req_valid), 32'd1);
                check("R1 req_addr", 32'(req_addr), 32'h0);
                check("R7 R1 req_seg", 32'(req_seg), 32'd0);
                check("R1 pulses", 32'({ir_valid, ret_strobe, call_err}), 32'd0);

                for (int i = 0; i < N_EVT; i++) begin
                    wait_event(got);
                    check(tag_of(i), 32'(got), 32'(EVT[i]));
                    @(negedge clk);
                    check("R9 single pulse", 32'({ir_valid, ret_strobe, call_err}), 32'd0);
                end

                // R8: stall memory right after reset
                rst_n = 1'b0;
                hold  = 1'b1;
                @(negedge clk);
                rst_n = 1'b1;
                repeat (6) @(negedge clk);
                check("R8 no new request", 32'(req_valid), 32'd0);
                check("R8 no output", 32'({ir_valid, ret_strobe, call_err}), 32'd0);
                hold = 1'b0;
                wait_event(got);
                check("R8 resumes", 32'(got), 32'(EVT[0]));

                // R7/R4: into firmware, then reset mid-routine (R1)
                wait_event(got);
                check("R3 enter routine", 32'(got), 32'(EVT[1]));
                check("R7 rom seg", 32'(req_seg), 32'd1);
                check("R4 fw next addr", 32'(req_addr), 32'h0011);
                rst_n = 1'b0;
                @(negedge clk);
                check("R1 seg after reset", 32'(req_seg), 32'd0);
                check("R1 addr after reset", 32'(req_addr), 32'h0);
                check("R1 pulses after reset", 32'({ir_valid, ret_strobe, call_err}), 32'd0);
                rst_n = 1'b1;
                wait_event(got);
                check("R1 restart at 0", 32'(got), 32'(EVT[0]));
            end
            begin
                repeat (20000) @(posedge clk);
                check("watchdog expired", 32'd0, 32'd1);
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule